// File: doc/BRIEF.md
# SPI Serial Clock Rate Generator

This block makes the serial clock for an SPI master from the system clock. Two counters run one after the other. The first is an optional prescaler that divides by a fixed 16. The second is a modulus counter that divides by (PM+1). The output of the modulus counter is a quarter-period tick, and two quarter ticks make one half period of SCK. The resulting rate is clk / ((DIV16 ? 16 : 1) * 4 * (PM+1)). Turn the prescaler on when the needed ratio of system clock to SCK is more than 64.

The transaction engine raises `run_i` to start the clock and drops it to stop it. On the first cycle of `run_i`, the block takes the prescaler select, the modulus and the idle level from the active chip select's mode word, clears both counters, and parks SCK at the idle level. The first half period is therefore always full length. Each change of SCK comes with a one-cycle toggle strobe. A lead strobe marks each move away from the idle level, and a trail strobe marks each return to it. The shifter uses these strobes to launch and sample data. While `run_i` is low, SCK follows the idle level and no strobes are produced.

Top module: `spi_baud_gen`

## Requirements
- R1: After reset, `sck_o` is 0 and `toggle_o`, `lead_o` and `trail_o` are all 0.
- R2: While `run_i` is low, `sck_o` takes the value of `idle_high_i` one clock later, and no strobe is asserted.
- R3: With the prescaler bit (bit 28 of `mode_word_i`) clear, each SCK half period lasts 2*(PM+1) clocks, where PM is bits 27:24 of the mode word. This holds for PM from 0 to 15. All other bits of the mode word have no effect on timing.
- R4: With bit 28 set, each half period lasts 16*2*(PM+1) clocks.
- R5: If `run_i` is first sampled high at clock edge 1, SCK first changes at edge H+1, where H is the half-period length from R3/R4. The first half period is never shortened.
- R6: `toggle_o` pulses for exactly one cycle, in the same cycle that `sck_o` changes. `lead_o` pulses with a change away from the captured idle level, and `trail_o` pulses with a change back to it. They never pulse together, and their OR equals `toggle_o`.
- R7: The mode word and `idle_high_i` are captured on the first cycle of `run_i`. Changes to them while `run_i` stays high affect neither the half-period length nor the level SCK returns to.
- R8: When `run_i` drops, `sck_o` goes to the idle level at the next edge and the counters clear. A later restart again gives a full first half period, as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Start (rise) and stop (fall) from the transaction engine |
| mode_word_i | input | 32 | Active chip select mode word; bit 28 selects the prescaler, bits 27:24 hold PM |
| idle_high_i | input | 1 | SCK idle level (1 = idles high) |
| sck_o | output | 1 | Serial clock level |
| toggle_o | output | 1 | One-cycle pulse with every SCK change |
| lead_o | output | 1 | Pulse when SCK leaves the idle level |
| trail_o | output | 1 | Pulse when SCK returns to the idle level |

## Verification
The bench covers the extremes of the modulus (PM of 0 and 15), both prescaler settings, and mode words with unrelated bits set. A design with an off-by-one in either counter, or one that decodes the wrong bits, would show the wrong gap between toggles. Other tests restart the clock after a stop partway through a half period, and rewrite the configuration and polarity while the clock is running. A design that does not clear its counters would give a short first half period. A design that reads the configuration live would change its rate or its idle level partway through a transaction. The bench also checks which strobe comes with each edge, so swapped lead and trail strobes are caught.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;
  localparam int unsigned MOD_W = 4;

  typedef struct packed {
    logic             pre_en;
    logic [MOD_W-1:0] modulus;
    logic             idle_lvl;
  } baud_cfg_t;

  // Clocks per SCK half period: prescale * 2 quarters * (modulus+1)
  function automatic int unsigned half_clocks(input logic pre_en,
                                              input logic [MOD_W-1:0] modulus,
                                              input int unsigned pre_div);
    int unsigned scale;
    scale = pre_en ? pre_div : 1;
    return scale * 2 * (int'(modulus) + 1);
  endfunction
endpackage

// File: rtl/spi_baud_prescale.sv
module spi_baud_prescale #(
  parameter int unsigned PRE_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cnt_en,
  input  logic use_pre,
  output logic pre_tick
);
  localparam int unsigned CW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRE_DIV - 1);

  generate
    if (PRE_DIV > 1) begin : g_div
      logic [CW-1:0] cnt_q;
      logic          wrap;
      assign wrap = (cnt_q == LAST);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (clr)               cnt_q <= '0;
        else if (cnt_en && use_pre) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      end
      assign pre_tick = cnt_en && (!use_pre || wrap);
    end else begin : g_pass
      assign pre_tick = cnt_en;
    end
  endgenerate
endmodule

// File: rtl/spi_baud_modulus.sv
module spi_baud_modulus #(
  parameter int unsigned MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [MW-1:0] limit,
  output logic          q_tick
);
  logic [MW-1:0] cnt_q;
  logic          at_limit;

  assign at_limit = (cnt_q == limit);
  assign q_tick   = step && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (step)  cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_baud_phase.sv
module spi_baud_phase #(
  parameter int unsigned QPH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic hold_lvl,
  input  logic q_tick,
  input  logic idle_lvl,
  output logic half_done,
  output logic sck,
  output logic toggle,
  output logic lead,
  output logic trail
);
  localparam int unsigned QW = (QPH > 1) ? $clog2(QPH) : 1;
  localparam logic [QW-1:0] QLAST = QW'(QPH - 1);

  logic [QW-1:0] qcnt_q;

  assign half_done = q_tick && (qcnt_q == QLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      qcnt_q <= '0;
    else if (hold)   qcnt_q <= '0;
    else if (q_tick) qcnt_q <= (qcnt_q == QLAST) ? '0 : qcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck    <= 1'b0;
      toggle <= 1'b0;
      lead   <= 1'b0;
      trail  <= 1'b0;
    end else if (hold) begin
      sck    <= hold_lvl;
      toggle <= 1'b0;
      lead   <= 1'b0;
      trail  <= 1'b0;
    end else begin
      toggle <= half_done;
      lead   <= half_done && (sck == idle_lvl);
      trail  <= half_done && (sck != idle_lvl);
      if (half_done) sck <= ~sck;
    end
  end
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
  import spi_baud_pkg::*;
#(
  parameter int unsigned CFG_W   = 32,
  parameter int unsigned PM_LSB  = 24,
  parameter int unsigned PRE_BIT = 28,
  parameter int unsigned PRE_DIV = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CFG_W-1:0] mode_word_i,
  input  logic             idle_high_i,
  output logic             sck_o,
  output logic             toggle_o,
  output logic             lead_o,
  output logic             trail_o
);
  localparam int unsigned QUARTERS_PER_HALF = 2;

  logic      active_q;
  logic      start_w;
  logic      counting_w;
  logic      pre_tick_w;
  logic      quarter_tick_w;
  logic      half_done_w;
  baud_cfg_t cfg_q;
  baud_cfg_t cfg_in;

  assign cfg_in.pre_en   = mode_word_i[PRE_BIT];
  assign cfg_in.modulus  = mode_word_i[PM_LSB +: MOD_W];
  assign cfg_in.idle_lvl = idle_high_i;

  assign start_w    = run_i && !active_q;
  assign counting_w = run_i && active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cfg_q    <= '0;
    end else begin
      active_q <= run_i;
      if (start_w) cfg_q <= cfg_in;
    end
  end

  spi_baud_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (!counting_w),
    .cnt_en   (counting_w),
    .use_pre  (cfg_q.pre_en),
    .pre_tick (pre_tick_w)
  );

  spi_baud_modulus #(.MW(MOD_W)) u_mod (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!counting_w),
    .step   (pre_tick_w),
    .limit  (cfg_q.modulus),
    .q_tick (quarter_tick_w)
  );

  spi_baud_phase #(.QPH(QUARTERS_PER_HALF)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (!counting_w),
    .hold_lvl  (idle_high_i),
    .q_tick    (quarter_tick_w),
    .idle_lvl  (cfg_q.idle_lvl),
    .half_done (half_done_w),
    .sck       (sck_o),
    .toggle    (toggle_o),
    .lead      (lead_o),
    .trail     (trail_o)
  );
endmodule

// File: rtl/spi_baud_checker.sv
module spi_baud_checker
  import spi_baud_pkg::*;
#(
  parameter int unsigned PRE_DIV = 16
) (
  input logic      clk,
  input logic      rst_n,
  input logic      run_i,
  input logic      idle_high_i,
  input logic      sck_o,
  input logic      toggle_o,
  input logic      lead_o,
  input logic      trail_o,
  input logic      counting_w,
  input logic      pre_tick_w,
  input logic      quarter_tick_w,
  input logic      half_done_w,
  input baud_cfg_t cfg_q
);
  int unsigned gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           gap_q <= 0;
    else if (!counting_w) gap_q <= 0;
    else if (half_done_w) gap_q <= 0;
    else                  gap_q <= gap_q + 1;
  end

  p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (sck_o == $past(idle_high_i)) && !toggle_o);

  // R3 and R4: half-period length
  p_half_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    half_done_w |-> gap_q == half_clocks(cfg_q.pre_en, cfg_q.modulus, PRE_DIV) - 1);

  p_tick_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    quarter_tick_w |-> pre_tick_w);

  p_strobe_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    toggle_o |-> sck_o != $past(sck_o));

  p_edge_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lead_o, trail_o}) && (toggle_o == (lead_o || trail_o)));

  p_lead_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lead_o |-> sck_o != cfg_q.idle_lvl);

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (counting_w && $past(counting_w)) |-> $stable(cfg_q));
endmodule

bind spi_baud_gen spi_baud_checker #(.PRE_DIV(PRE_DIV)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .run_i          (run_i),
  .idle_high_i    (idle_high_i),
  .sck_o          (sck_o),
  .toggle_o       (toggle_o),
  .lead_o         (lead_o),
  .trail_o        (trail_o),
  .counting_w     (counting_w),
  .pre_tick_w     (pre_tick_w),
  .quarter_tick_w (quarter_tick_w),
  .half_done_w    (half_done_w),
  .cfg_q          (cfg_q)
);

// File: tb/tb_spi_baud_gen.sv
module tb_spi_baud_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_i = 1'b0;
  logic [31:0] mode_word_i = '0;
  logic        idle_high_i = 1'b0;
  logic        sck_o, toggle_o, lead_o, trail_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  spi_baud_gen dut (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .mode_word_i(mode_word_i),
    .idle_high_i(idle_high_i), .sck_o(sck_o), .toggle_o(toggle_o),
    .lead_o(lead_o), .trail_o(trail_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] mk(input logic pre, input int pm, input logic [31:0] junk);
    logic [31:0] w;
    w = junk & ~32'h1F00_0000;
    w[28] = pre;
    w[27:24] = 4'(pm);
    return w;
  endfunction

  function automatic int exp_half(input logic pre, input int pm);
    return (pre ? 16 : 1) * (pm + 1) * 2;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_toggle(output int n);
    n = 0;
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); @(negedge clk);
      n++;
      if (toggle_o) break;
    end
  endtask

  task automatic stop_and_check(input string req);
    @(negedge clk); run_i = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(req, {sck_o, toggle_o}, {idle_high_i, 1'b0});
  endtask

  // R3 R4 R5 R6: full run of three edges
  task automatic t_rate(input string req, input logic pre, input int pm,
                        input logic idle, input logic [31:0] junk);
    int n;
    int h;
    h = exp_half(pre, pm);
    @(negedge clk);
    mode_word_i = mk(pre, pm, junk); idle_high_i = idle; run_i = 1'b1;
    wait_toggle(n);
    chk({req, " R5 first half"}, n, h + 1);
    chk({req, " R6 lead"}, {lead_o, trail_o, sck_o}, {1'b1, 1'b0, ~idle});
    wait_toggle(n);
    chk({req, " half period"}, n, h);
    chk({req, " R6 trail"}, {lead_o, trail_o, sck_o}, {1'b0, 1'b1, idle});
    @(posedge clk); @(negedge clk);
    chk({req, " R6 single-cycle strobe"}, toggle_o, 0);
    wait_toggle(n);
    chk({req, " half period 3"}, n, h - 1);
    stop_and_check({req, " R8 stop"});
  endtask

  task automatic t_reset;
    chk("R1 reset outputs", {sck_o, toggle_o, lead_o, trail_o}, 0);
  endtask

  task automatic t_idle_follow;
    int seen;
    seen = 0;
    @(negedge clk); run_i = 1'b0; idle_high_i = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R2 idle high", sck_o, 1);
    idle_high_i = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R2 idle low", sck_o, 0);
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); @(negedge clk);
      if (toggle_o || lead_o || trail_o) seen++;
    end
    chk("R2 no strobes while stopped", seen, 0);
  endtask

  task automatic t_cfg_capture;
    int n;
    @(negedge clk);
    mode_word_i = mk(1'b0, 1, 32'h0); idle_high_i = 1'b0; run_i = 1'b1;
    wait_toggle(n);
    chk("R7 first half", n, 5);
    mode_word_i = mk(1'b1, 7, 32'h0); idle_high_i = 1'b1;
    wait_toggle(n);
    chk("R7 rate kept after rewrite", n, 4);
    chk("R7 idle kept (trail back to 0)", {trail_o, sck_o}, {1'b1, 1'b0});
    wait_toggle(n);
    chk("R7 lead still away from 0", {lead_o, sck_o}, {1'b1, 1'b1});
    stop_and_check("R8 stop to new idle");
  endtask

  task automatic t_restart;
    int n;
    @(negedge clk);
    mode_word_i = mk(1'b0, 2, 32'h0); idle_high_i = 1'b0; run_i = 1'b1;
    repeat (3) @(negedge clk);
    run_i = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R8 stopped mid half", {sck_o, toggle_o}, 0);
    run_i = 1'b1;
    wait_toggle(n);
    chk("R8 restart full first half", n, 7);
    stop_and_check("R8 stop after restart");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_idle_follow();
    t_rate("R3 pm0",         1'b0, 0,  1'b0, 32'h0);
    t_rate("R3 pm5 junk",    1'b0, 5,  1'b1, 32'hE0F3_FFFF);
    t_rate("R3 pm15",        1'b0, 15, 1'b0, 32'h0000_1234);
    t_rate("R4 pre pm0",     1'b1, 0,  1'b1, 32'h0);
    t_rate("R4 pre pm3",     1'b1, 3,  1'b0, 32'h8000_0001);
    t_cfg_capture();
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule